// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-facing side of a classic byte-wide UART. It checks a three-wire chip select, captures a 3-bit register offset through an address strobe latch, and accepts read and write strobes in either polarity. Writes land in the control registers, the transmit holding register or the divisor bytes. Reads return the addressed register, or status bytes supplied by the serial core.

Bit 7 of the line control register is the divisor access bit. While it is set, offsets 0 and 1 map onto the low and high divisor bytes. While it is clear, they map onto the data path and the interrupt enable register. The serial shifters, the baud counter and the interrupt priority logic sit outside the block and connect through its ports. The block emits a load pulse toward the transmitter and a "byte taken" pulse toward the receiver.

Top module: `uart_host_regif`

## Requirements
- R1: The block is selected only when `cs_a`=1, `cs_b`=1 and `cs_lo_n`=0. When it is not selected, `dout` is 0x00 and no write changes any register.
- R2: While `adr_stb_n` is low, the offset follows `adr` directly. While it is high, the offset stays at the last value `adr` had while the strobe was low.
- R3: A read is enabled by `rd`=1 or `rd_n`=0, and a write by `wr`=1 or `wr_n`=0. Both polarities work the same way. When no read is enabled, `dout` is 0x00.
- R4: A write updates its register once, with `din` sampled at the first clock edge where the write enable is seen active. Holding the strobe longer changes nothing more.
- R5: When bit 7 of line control is set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. `divisor` shows {high, low}.
- R6: With bit 7 of line control clear, the offsets are as follows. Offset 0 reads `rx_byte` and writes the transmit holding register. Offset 1 is interrupt enable. Offset 2 is interrupt identification. Offset 3 is line control. Offset 4 is modem control. Offset 5 reads `line_stat` and offset 6 reads `modem_stat`. Offset 7 is scratch. Writes to offsets 2, 5 and 6 are ignored.
- R7: Interrupt enable keeps only bits 3:0 and modem control keeps only bits 4:0. The remaining bits read 0.
- R8: A write to offset 0 with the divisor bit clear sets `tx_byte` to the written data. `tx_load` is high for exactly the one cycle after that write edge.
- R9: `rx_taken` is high only during the first cycle of a read of offset 0 with the divisor bit clear, and `dout` equals `rx_byte` during that cycle.
- R10: While `mr`=1, interrupt enable, line control, modem control and scratch read 0x00 and interrupt identification reads 0x01. After reset, interrupt identification reads {5'b0, `irq_code`} registered one cycle.
- R11: `mr` leaves `tx_byte` and `divisor` unchanged. Writes attempted while `mr`=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mr | input | 1 | Master reset, synchronous, active high |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adr_stb_n | input | 1 | Address strobe; low = transparent, high = hold |
| adr | input | 3 | Register offset |
| din | input | 8 | Write data |
| rd | input | 1 | Read strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr | input | 1 | Write strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| rx_byte | input | 8 | Received byte from the receiver |
| line_stat | input | 8 | Line status from the serial core |
| modem_stat | input | 8 | Modem status from the serial core |
| irq_code | input | 3 | Interrupt identification code from priority logic |
| dout | output | 8 | Read data |
| tx_byte | output | 8 | Transmit holding register contents |
| tx_load | output | 1 | One-cycle load pulse toward the transmitter |
| rx_taken | output | 1 | One-cycle pulse when the received byte is read |
| divisor | output | 16 | Baud divisor {high, low} |
| ier_o | output | 8 | Interrupt enable register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |

## Verification
Some rules hold on every cycle, and the assertions check those. A deselected block drives a zero read bus and changes no register. `tx_load` never lasts two cycles. `rx_taken` coincides with `dout` carrying `rx_byte`. Reset clears the control registers and holds the divisor and transmit byte steady.

Other behaviour only the bench scenarios can show. These include capturing the offset on a strobe rising edge versus following it while transparent, and the divisor aliasing as the line control bit is toggled. They also include a single update from a held write strobe and the masking of interrupt-enable and modem-control bits.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int DIV_W     = 2 * DATA_W;
    localparam logic [DATA_W-1:0] IID_IDLE = 8'h01;
    localparam int DLAB_BIT  = DATA_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DATA    = 3'd0,
        OFF_IEN     = 3'd1,
        OFF_IID     = 3'd2,
        OFF_LCTL    = 3'd3,
        OFF_MCTL    = 3'd4,
        OFF_LSTAT   = 3'd5,
        OFF_MSTAT   = 3'd6,
        OFF_SCRATCH = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic              rd_en;
        logic              rd_first;
        logic              wr_first;
        reg_off_e          off;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic thr;
        logic dll;
        logic dlm;
        logic ien;
        logic lctl;
        logic mctl;
        logic scr;
    } wr_sel_t;

    function automatic logic chip_selected(input logic a, input logic b, input logic lo_n);
        return a & b & ~lo_n;
    endfunction

    function automatic logic strobe_active(input logic hi, input logic lo_n);
        return hi | ~lo_n;
    endfunction

    function automatic logic [DATA_W-1:0] keep_low(input logic [DATA_W-1:0] v, input int bits);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < bits);
        return v & m;
    endfunction

endpackage

// File: rtl/regif_front.sv
module regif_front
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              mr,
    input  logic              cs_a,
    input  logic              cs_b,
    input  logic              cs_lo_n,
    input  logic              adr_stb_n,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] din,
    input  logic              rd,
    input  logic              rd_n,
    input  logic              wr,
    input  logic              wr_n,
    output host_req_t         req
);

    logic              sel;
    logic              rd_en, wr_en;
    logic              rd_seen, wr_seen;
    logic [ADDR_W-1:0] adr_hold;

    // Strobe latch: follows the bus while the strobe is low, freezes when it rises.
    always_ff @(posedge clk) begin
        if (mr)              adr_hold <= '0;
        else if (!adr_stb_n) adr_hold <= adr;
    end

    always_ff @(posedge clk) begin
        if (mr) begin
            rd_seen <= 1'b0;
            wr_seen <= 1'b0;
        end else begin
            rd_seen <= rd_en;
            wr_seen <= wr_en;
        end
    end

    always_comb begin
        sel   = chip_selected(cs_a, cs_b, cs_lo_n);
        rd_en = sel & strobe_active(rd, rd_n);
        wr_en = sel & strobe_active(wr, wr_n);

        req.rd_en    = rd_en;
        req.rd_first = rd_en & ~rd_seen;
        req.wr_first = wr_en & ~wr_seen & ~mr;
        req.off      = reg_off_e'(adr_stb_n ? adr_hold : adr);
        req.wdata    = din;
    end

endmodule

// File: rtl/regif_regfile.sv
module regif_regfile
    import uart_regif_pkg::*;
#(
    parameter int IEN_BITS  = 4,
    parameter int MCTL_BITS = 5
) (
    input  logic              clk,
    input  logic              mr,
    input  logic              wr_first,
    input  reg_off_e          off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [2:0]        irq_code,
    output logic [DATA_W-1:0] thr_q,
    output logic [DATA_W-1:0] dll_q,
    output logic [DATA_W-1:0] dlm_q,
    output logic [DATA_W-1:0] ien_q,
    output logic [DATA_W-1:0] lctl_q,
    output logic [DATA_W-1:0] mctl_q,
    output logic [DATA_W-1:0] scr_q,
    output logic [DATA_W-1:0] iid_q,
    output logic              thr_load
);

    localparam int IID_PAD = DATA_W - 3;

    wr_sel_t we;
    logic    dlab;

    assign dlab = lctl_q[DLAB_BIT];

    always_comb begin
        we = '0;
        if (wr_first) begin
            unique case (off)
                OFF_DATA:    if (dlab) we.dll = 1'b1; else we.thr = 1'b1;
                OFF_IEN:     if (dlab) we.dlm = 1'b1; else we.ien = 1'b1;
                OFF_LCTL:    we.lctl = 1'b1;
                OFF_MCTL:    we.mctl = 1'b1;
                OFF_SCRATCH: we.scr  = 1'b1;
                default:     we = '0;
            endcase
        end
    end

    // Control registers: cleared by master reset.
    always_ff @(posedge clk) begin
        if (mr) begin
            ien_q    <= '0;
            lctl_q   <= '0;
            mctl_q   <= '0;
            scr_q    <= '0;
            iid_q    <= IID_IDLE;
            thr_load <= 1'b0;
        end else begin
            if (we.ien)  ien_q  <= keep_low(wdata, IEN_BITS);
            if (we.lctl) lctl_q <= wdata;
            if (we.mctl) mctl_q <= keep_low(wdata, MCTL_BITS);
            if (we.scr)  scr_q  <= wdata;
            iid_q    <= {{IID_PAD{1'b0}}, irq_code};
            thr_load <= we.thr;
        end
    end

    // Data holding and divisor bytes: untouched by master reset.
    always_ff @(posedge clk) begin
        if (we.thr) thr_q <= wdata;
        if (we.dll) dll_q <= wdata;
        if (we.dlm) dlm_q <= wdata;
    end

endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
    import uart_regif_pkg::*;
(
    input  logic              rd_en,
    input  logic              rd_first,
    input  reg_off_e          off,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] line_stat,
    input  logic [DATA_W-1:0] modem_stat,
    input  logic [DATA_W-1:0] dll_q,
    input  logic [DATA_W-1:0] dlm_q,
    input  logic [DATA_W-1:0] ien_q,
    input  logic [DATA_W-1:0] lctl_q,
    input  logic [DATA_W-1:0] mctl_q,
    input  logic [DATA_W-1:0] scr_q,
    input  logic [DATA_W-1:0] iid_q,
    output logic [DATA_W-1:0] dout,
    output logic              rx_taken
);

    logic              dlab;
    logic [DATA_W-1:0] sel_val;

    assign dlab = lctl_q[DLAB_BIT];

    always_comb begin
        unique case (off)
            OFF_DATA:    sel_val = dlab ? dll_q : rx_byte;
            OFF_IEN:     sel_val = dlab ? dlm_q : ien_q;
            OFF_IID:     sel_val = iid_q;
            OFF_LCTL:    sel_val = lctl_q;
            OFF_MCTL:    sel_val = mctl_q;
            OFF_LSTAT:   sel_val = line_stat;
            OFF_MSTAT:   sel_val = modem_stat;
            default:     sel_val = scr_q;
        endcase
        dout     = rd_en ? sel_val : '0;
        rx_taken = rd_first & ~dlab & (off == OFF_DATA);
    end

endmodule

// File: rtl/uart_host_regif.sv
module uart_host_regif
    import uart_regif_pkg::*;
#(
    parameter int IEN_BITS  = 4,
    parameter int MCTL_BITS = 5
) (
    input  logic        clk,
    input  logic        mr,
    input  logic        cs_a,
    input  logic        cs_b,
    input  logic        cs_lo_n,
    input  logic        adr_stb_n,
    input  logic [2:0]  adr,
    input  logic [7:0]  din,
    input  logic        rd,
    input  logic        rd_n,
    input  logic        wr,
    input  logic        wr_n,
    input  logic [7:0]  rx_byte,
    input  logic [7:0]  line_stat,
    input  logic [7:0]  modem_stat,
    input  logic [2:0]  irq_code,
    output logic [7:0]  dout,
    output logic [7:0]  tx_byte,
    output logic        tx_load,
    output logic        rx_taken,
    output logic [15:0] divisor,
    output logic [7:0]  ier_o,
    output logic [7:0]  lcr_o,
    output logic [7:0]  mcr_o
);

    host_req_t         req;
    logic [DATA_W-1:0] dll_q, dlm_q, scr_q, iid_q;

    regif_front u_front (
        .clk       (clk),
        .mr        (mr),
        .cs_a      (cs_a),
        .cs_b      (cs_b),
        .cs_lo_n   (cs_lo_n),
        .adr_stb_n (adr_stb_n),
        .adr       (adr),
        .din       (din),
        .rd        (rd),
        .rd_n      (rd_n),
        .wr        (wr),
        .wr_n      (wr_n),
        .req       (req)
    );

    regif_regfile #(
        .IEN_BITS  (IEN_BITS),
        .MCTL_BITS (MCTL_BITS)
    ) u_regs (
        .clk      (clk),
        .mr       (mr),
        .wr_first (req.wr_first),
        .off      (req.off),
        .wdata    (req.wdata),
        .irq_code (irq_code),
        .thr_q    (tx_byte),
        .dll_q    (dll_q),
        .dlm_q    (dlm_q),
        .ien_q    (ier_o),
        .lctl_q   (lcr_o),
        .mctl_q   (mcr_o),
        .scr_q    (scr_q),
        .iid_q    (iid_q),
        .thr_load (tx_load)
    );

    regif_rdmux u_rdmux (
        .rd_en      (req.rd_en),
        .rd_first   (req.rd_first),
        .off        (req.off),
        .rx_byte    (rx_byte),
        .line_stat  (line_stat),
        .modem_stat (modem_stat),
        .dll_q      (dll_q),
        .dlm_q      (dlm_q),
        .ien_q      (ier_o),
        .lctl_q     (lcr_o),
        .mctl_q     (mcr_o),
        .scr_q      (scr_q),
        .iid_q      (iid_q),
        .dout       (dout),
        .rx_taken   (rx_taken)
    );

    assign divisor = {dlm_q, dll_q};

endmodule

// File: rtl/uart_host_regif_chk.sv
module uart_host_regif_chk (
    input logic        clk,
    input logic        mr,
    input logic        cs_a,
    input logic        cs_b,
    input logic        cs_lo_n,
    input logic [7:0]  rx_byte,
    input logic [7:0]  dout,
    input logic [7:0]  tx_byte,
    input logic        tx_load,
    input logic        rx_taken,
    input logic [15:0] divisor,
    input logic [7:0]  ier_o,
    input logic [7:0]  lcr_o,
    input logic [7:0]  mcr_o
);

    logic picked;
    assign picked = cs_a && cs_b && !cs_lo_n;

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (mr)
        !picked |-> dout == 8'h00);

    assert_deselect_no_write_R1: assert property (@(posedge clk) disable iff (mr)
        !picked |=> $stable(lcr_o) && $stable(ier_o) && $stable(mcr_o)
                    && $stable(divisor) && $stable(tx_byte));

    assert_load_single_R8: assert property (@(posedge clk) disable iff (mr)
        tx_load |=> !tx_load);

    assert_taken_shows_rx_R9: assert property (@(posedge clk) disable iff (mr)
        rx_taken |-> dout == rx_byte);

    assert_reset_clears_R10: assert property (@(posedge clk)
        mr |=> lcr_o == 8'h00 && ier_o == 8'h00 && mcr_o == 8'h00 && !tx_load);

    assert_reset_keeps_data_R11: assert property (@(posedge clk)
        mr |=> $stable(divisor) && $stable(tx_byte));

endmodule

bind uart_host_regif uart_host_regif_chk u_chk (
    .clk      (clk),
    .mr       (mr),
    .cs_a     (cs_a),
    .cs_b     (cs_b),
    .cs_lo_n  (cs_lo_n),
    .rx_byte  (rx_byte),
    .dout     (dout),
    .tx_byte  (tx_byte),
    .tx_load  (tx_load),
    .rx_taken (rx_taken),
    .divisor  (divisor),
    .ier_o    (ier_o),
    .lcr_o    (lcr_o),
    .mcr_o    (mcr_o)
);

// File: tb/uart_host_regif_tb.sv
module uart_host_regif_tb;

    logic        clk = 1'b0;
    logic        mr;
    logic        cs_a, cs_b, cs_lo_n, adr_stb_n;
    logic [2:0]  adr;
    logic [7:0]  din;
    logic        rd, rd_n, wr, wr_n;
    logic [7:0]  rx_byte, line_stat, modem_stat;
    logic [2:0]  irq_code;
    logic [7:0]  dout, tx_byte, ier_o, lcr_o, mcr_o;
    logic        tx_load, rx_taken;
    logic [15:0] divisor;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_host_regif u_dut (
        .clk(clk), .mr(mr), .cs_a(cs_a), .cs_b(cs_b), .cs_lo_n(cs_lo_n),
        .adr_stb_n(adr_stb_n), .adr(adr), .din(din), .rd(rd), .rd_n(rd_n),
        .wr(wr), .wr_n(wr_n), .rx_byte(rx_byte), .line_stat(line_stat),
        .modem_stat(modem_stat), .irq_code(irq_code), .dout(dout),
        .tx_byte(tx_byte), .tx_load(tx_load), .rx_taken(rx_taken),
        .divisor(divisor), .ier_o(ier_o), .lcr_o(lcr_o), .mcr_o(mcr_o)
    );

    // {cs_a, cs_b, cs_lo_n, data written to scratch, expected scratch afterwards}
    localparam logic [18:0] CS_VEC [8] = '{
        {3'b000, 8'h11, 8'h00}, {3'b001, 8'h22, 8'h00},
        {3'b010, 8'h33, 8'h00}, {3'b011, 8'h44, 8'h00},
        {3'b100, 8'h55, 8'h00}, {3'b101, 8'h66, 8'h00},
        {3'b110, 8'h77, 8'h77}, {3'b111, 8'h88, 8'h77}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        cs_a = 1'b0; cs_b = 1'b0; cs_lo_n = 1'b1;
        rd = 1'b0; rd_n = 1'b1; wr = 1'b0; wr_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d,
                          input logic [2:0] cs, input bit inv);
        @(negedge clk);
        {cs_a, cs_b, cs_lo_n} = cs;
        adr = a; din = d;
        if (inv) wr_n = 1'b0; else wr = 1'b1;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic rd_reg(input logic [2:0] a, input bit inv,
                          output logic [7:0] q, output logic pulse);
        @(negedge clk);
        {cs_a, cs_b, cs_lo_n} = 3'b110;
        adr = a;
        if (inv) rd_n = 1'b0; else rd = 1'b1;
        #1;
        q = dout; pulse = rx_taken;
        @(negedge clk);
        bus_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic       p;
        bus_idle();
        mr = 1'b1; adr_stb_n = 1'b0; adr = '0; din = '0;
        rx_byte = 8'hC7; line_stat = 8'h60; modem_stat = 8'hB0; irq_code = 3'b001;
        repeat (3) @(negedge clk);

        // R10: reset values, read while reset is held
        rd_reg(3'd2, 0, q, p); chk("R10 iid reset", q, 8'h01);
        rd_reg(3'd1, 0, q, p); chk("R10 ien reset", q, 8'h00);
        rd_reg(3'd7, 0, q, p); chk("R10 scratch reset", q, 8'h00);
        chk("R10 lcr/mcr reset", {lcr_o, mcr_o}, 16'h0000);
        @(negedge clk); mr = 1'b0;

        // R1: every chip-select combination, table driven
        foreach (CS_VEC[i]) begin
            wr_reg(3'd7, CS_VEC[i][15:8], CS_VEC[i][18:16], 0);
            @(negedge clk);
            {cs_a, cs_b, cs_lo_n} = CS_VEC[i][18:16]; adr = 3'd7; rd = 1'b1;
            #1;
            chk("R1 read gated", {8'h00, dout},
                {8'h00, (CS_VEC[i][18:16] == 3'b110) ? CS_VEC[i][7:0] : 8'h00});
            @(negedge clk); bus_idle();
            rd_reg(3'd7, 0, q, p);
            chk("R1 scratch after select combo", q, CS_VEC[i][7:0]);
        end

        // R3: inverted strobes
        wr_reg(3'd7, 8'h3E, 3'b110, 1);
        rd_reg(3'd7, 1, q, p); chk("R3 inverted strobes", q, 8'h3E);
        @(negedge clk); #1; chk("R3 idle dout zero", dout, 8'h00);

        // R4: held write, din changes after the first edge
        @(negedge clk);
        {cs_a, cs_b, cs_lo_n} = 3'b110; adr = 3'd7; din = 8'h5A; wr = 1'b1;
        @(negedge clk); din = 8'hC3;
        @(negedge clk); bus_idle();
        rd_reg(3'd7, 0, q, p); chk("R4 single update", q, 8'h5A);

        // R6 / R7: offsets, read-only, masking
        wr_reg(3'd5, 8'hFF, 3'b110, 0);
        rd_reg(3'd5, 0, q, p); chk("R6 line status read-only", q, 8'h60);
        rd_reg(3'd6, 0, q, p); chk("R6 modem status", q, 8'hB0);
        wr_reg(3'd2, 8'hFF, 3'b110, 0);
        rd_reg(3'd2, 0, q, p); chk("R6 iid read-only", q, 8'h01);
        wr_reg(3'd1, 8'hFF, 3'b110, 0);
        rd_reg(3'd1, 0, q, p); chk("R7 ien mask", q, 8'h0F);
        wr_reg(3'd4, 8'hFF, 3'b110, 0);
        rd_reg(3'd4, 0, q, p); chk("R7 mcr mask", q, 8'h1F);

        // R10: iid follows irq_code after reset
        irq_code = 3'b110;
        rd_reg(3'd2, 0, q, p); chk("R10 iid follows code", q, 8'h06);
        irq_code = 3'b001;

        // R5: divisor access toggled
        wr_reg(3'd3, 8'h83, 3'b110, 0);
        wr_reg(3'd0, 8'h34, 3'b110, 0);
        chk("R5 no tx load under dlab", {15'd0, tx_load}, 16'd0);
        wr_reg(3'd1, 8'h12, 3'b110, 0);
        chk("R5 divisor", divisor, 16'h1234);
        rd_reg(3'd0, 0, q, p); chk("R5 read dll", {7'd0, p, q}, {8'h00, 8'h34});
        rd_reg(3'd1, 0, q, p); chk("R5 read dlm", q, 8'h12);
        wr_reg(3'd3, 8'h03, 3'b110, 0);
        rd_reg(3'd1, 0, q, p); chk("R5 ien back", q, 8'h0F);

        // R8: transmit holding write and load pulse
        wr_reg(3'd0, 8'hA5, 3'b110, 0);
        chk("R8 load pulse", {tx_byte, 7'd0, tx_load}, {8'hA5, 8'h01});
        @(negedge clk); chk("R8 pulse ends", {15'd0, tx_load}, 16'd0);

        // R9: receive read pulse, first cycle only
        @(negedge clk);
        {cs_a, cs_b, cs_lo_n} = 3'b110; adr = 3'd0; rd_n = 1'b0;
        #1; chk("R9 taken pulse", {7'd0, rx_taken, dout}, {8'h01, 8'hC7});
        @(negedge clk); #1; chk("R9 pulse once", {15'd0, rx_taken}, 16'd0);
        @(negedge clk); bus_idle();

        // R2: strobe freeze then transparent
        @(negedge clk); adr_stb_n = 1'b0; adr = 3'd7;
        @(negedge clk); adr_stb_n = 1'b1;
        wr_reg(3'd3, 8'h9C, 3'b110, 0);
        chk("R2 frozen address", lcr_o, 8'h03);
        @(negedge clk); adr_stb_n = 1'b0;
        rd_reg(3'd7, 0, q, p); chk("R2 transparent read", q, 8'h9C);

        // R11: reset keeps divisor and holding register; writes in reset ignored
        @(negedge clk); mr = 1'b1;
        wr_reg(3'd0, 8'h11, 3'b110, 0);
        @(negedge clk); mr = 1'b0;
        chk("R11 divisor kept", divisor, 16'h1234);
        chk("R11 tx byte kept", {8'h00, tx_byte}, {8'h00, 8'hA5});
        chk("R11 lcr cleared", {8'h00, lcr_o}, 16'h0000);
        rd_reg(3'd0, 0, q, p); chk("R11 offset0 is rx after reset", q, 8'hC7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule